// File: doc/BRIEF.md
# Prefixed register move unit

This block carries out one register-to-register move in each instruction cycle of a small controller datapath. Every register is either 8 or 16 bits wide. The unit takes the word read from the source register, its width, and the width of the destination, and produces the word to write together with a write enable. The destination register takes that word on the next clock edge. All of this happens in the same cycle as the move strobe, so a move costs one cycle.

A one-cycle prefix byte fills the upper half of a wide destination when the source is narrow. Software loads the prefix in the cycle just before the move that uses it. If any other cycle comes between the load and the move, the prefix reads as zero.

Addresses that no register answers to follow fixed rules:

- **Undefined destination:** the move writes nothing. The source is still told it was read, so it can apply a side effect such as a pointer post-decrement.
- **Undefined source:** the unit substitutes a word whose value depends on the kind of module that owns the address.

Top module: `regmove_unit`

## Requirements
- R1: For a defined 8-bit source moved to an 8-bit destination, `wr_data[7:0]` equals `src_data[7:0]` and `wr_data[15:8]` is 00h.
- R2: For a defined 8-bit source moved to a 16-bit destination, `wr_data` is {prefix, `src_data[7:0]`}.
- R3: The prefix equals `pfx_value` if `pfx_load` was high in the immediately preceding cycle, and 00h otherwise.
- R4: For a 16-bit source moved to an 8-bit destination, `wr_data` is {00h, `src_data[7:0]`}.
- R5: For a 16-bit source moved to a 16-bit destination, `wr_data` equals `src_data`.
- R6: When `dst_defined` is low, `wr_en` stays low during a move, and `src_fx` is still raised if the source is defined.
- R7: An undefined source with `src_mod_wide` = 0 (its module holds 8-bit registers) supplies {prefix, 00h} as a 16-bit word. An 8-bit destination therefore receives 00h.
- R8: An undefined source with `src_mod_wide` = 1 (its module holds only 16-bit registers) supplies 0000h.
- R9: While `rst_n` is low, and for two clock edges after it rises, `wr_en` and `src_fx` are low. The prefix is 00h after reset.
- R10: `wr_en`, `wr_data` and `wr_idx` (equal to `dst_idx`) are valid in the same cycle as `mv_strobe`, with no register on the path.
- R11: A prefix load in the same cycle as a move does not affect that move. The move uses the prefix from the previous cycle, and the new value applies to the following cycle.
- R12: `src_fx` is high exactly in cycles where `mv_strobe` and `src_defined` are both high (outside reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mv_strobe | input | 1 | A move is executed this cycle |
| src_idx | input | IDX_W | Source register index |
| dst_idx | input | IDX_W | Destination register index |
| src_wide | input | 1 | Source register is 16 bits |
| dst_wide | input | 1 | Destination register is 16 bits |
| src_defined | input | 1 | Source address holds a register |
| dst_defined | input | 1 | Destination address holds a register |
| src_mod_wide | input | 1 | Source module holds only 16-bit registers |
| src_data | input | 2*BYTE_W | Word read from the source register |
| pfx_load | input | 1 | Load the prefix this cycle |
| pfx_value | input | BYTE_W | Prefix byte to load |
| rd_idx | output | IDX_W | Read index for the register file |
| wr_en | output | 1 | Destination write enable |
| wr_idx | output | IDX_W | Destination write index |
| wr_data | output | 2*BYTE_W | Destination write word |
| src_fx | output | 1 | Source side-effect strobe |

## Verification
A prefix load and a narrow-to-wide move can occur in the same cycle. The move must then use the prefix loaded in the cycle before, while the new byte must reach only the following move. The bench provokes this directly by loading in back-to-back moves, and at random by raising the load request in about a third of the random cycles. Each move is judged against a bench-side prefix model that keeps the previous cycle's load. A second collision, an undefined destination combined with a defined source, checks that the write is suppressed while the side-effect strobe still fires.

// File: rtl/regmove_pkg.sv
package regmove_pkg;

  // Kind of module that owns a source address
  typedef enum logic {
    SRC_MOD_MIXED = 1'b0,   // holds 8-bit registers (possibly with 16-bit ones)
    SRC_MOD_WIDE  = 1'b1    // holds only 16-bit registers
  } src_mod_e;

  // Operand resolved from the source side, before destination width merge
  typedef struct packed {
    logic wide;   // operand carries a meaningful upper byte
  } operand_attr_t;

endpackage

// File: rtl/regmove_rstsync.sv
// Reset synchronizer: asserts asynchronously, releases on the clock.
module regmove_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ok = sync_q[STAGES-1];

endmodule

// File: rtl/regmove_prefix.sv
// One-cycle prefix byte: holds a loaded value for one cycle, else zero.
module regmove_prefix #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  output logic [BYTE_W-1:0] pfx
);

  logic [BYTE_W-1:0] pfx_q;
  logic [BYTE_W-1:0] pfx_d;
  logic              pfx_en;

  always_comb begin
    pfx_d  = load ? load_val : '0;
    // Clock only when loading or when a held value must clear
    pfx_en = load | (|pfx_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_q <= '0;
    end else if (pfx_en) begin
      pfx_q <= pfx_d;
    end
  end

  assign pfx = pfx_q;

endmodule

// File: rtl/regmove_srcsel.sv
// Resolves the source operand, substituting a word for undefined sources.
module regmove_srcsel
  import regmove_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic [DATA_W-1:0] src_data,
  input  logic              src_wide,
  input  logic              src_defined,
  input  logic              src_mod_wide,
  input  logic [BYTE_W-1:0] pfx,
  output logic [DATA_W-1:0] opnd,
  output operand_attr_t     opnd_attr
);

  src_mod_e mod_kind;

  always_comb begin
    mod_kind = src_mod_e'(src_mod_wide);
    if (!src_defined) begin
      opnd_attr.wide = 1'b1;
      if (mod_kind == SRC_MOD_WIDE) begin
        opnd = '0;
      end else begin
        opnd = {pfx, {BYTE_W{1'b0}}};
      end
    end else if (src_wide) begin
      opnd_attr.wide = 1'b1;
      opnd           = src_data;
    end else begin
      opnd_attr.wide = 1'b0;
      opnd           = {{BYTE_W{1'b0}}, src_data[BYTE_W-1:0]};
    end
  end

endmodule

// File: rtl/regmove_merge.sv
// Builds the destination word byte lane by byte lane.
module regmove_merge
  import regmove_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W,
  localparam int LANES  = DATA_W / BYTE_W
) (
  input  logic [DATA_W-1:0] opnd,
  input  operand_attr_t     opnd_attr,
  input  logic              dst_wide,
  input  logic [BYTE_W-1:0] pfx,
  output logic [DATA_W-1:0] wr_word
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      // Low lane always carries the operand's low byte
      assign wr_word[BYTE_W-1:0] = opnd[BYTE_W-1:0];
    end else begin : g_high
      logic [BYTE_W-1:0] lane_q;
      always_comb begin
        if (!dst_wide) begin
          lane_q = '0;
        end else if (opnd_attr.wide) begin
          lane_q = opnd[g*BYTE_W +: BYTE_W];
        end else if (g == 1) begin
          lane_q = pfx;
        end else begin
          lane_q = '0;
        end
      end
      assign wr_word[g*BYTE_W +: BYTE_W] = lane_q;
    end
  end

endmodule

// File: rtl/regmove_unit.sv
module regmove_unit
  import regmove_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mv_strobe,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic              src_wide,
  input  logic              dst_wide,
  input  logic              src_defined,
  input  logic              dst_defined,
  input  logic              src_mod_wide,
  input  logic [DATA_W-1:0] src_data,
  input  logic              pfx_load,
  input  logic [BYTE_W-1:0] pfx_value,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              src_fx
);

  logic              rst_ok;
  logic [BYTE_W-1:0] pfx;
  logic [DATA_W-1:0] opnd;
  operand_attr_t     opnd_attr;

  regmove_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  regmove_prefix #(.BYTE_W(BYTE_W)) u_pfx (
    .clk      (clk),
    .rst_n    (rst_ok),
    .load     (pfx_load),
    .load_val (pfx_value),
    .pfx      (pfx)
  );

  regmove_srcsel #(.BYTE_W(BYTE_W)) u_src (
    .src_data     (src_data),
    .src_wide     (src_wide),
    .src_defined  (src_defined),
    .src_mod_wide (src_mod_wide),
    .pfx          (pfx),
    .opnd         (opnd),
    .opnd_attr    (opnd_attr)
  );

  regmove_merge #(.BYTE_W(BYTE_W)) u_merge (
    .opnd      (opnd),
    .opnd_attr (opnd_attr),
    .dst_wide  (dst_wide),
    .pfx       (pfx),
    .wr_word   (wr_data)
  );

  always_comb begin
    rd_idx = src_idx;
    wr_idx = dst_idx;
    wr_en  = rst_ok & mv_strobe & dst_defined;
    src_fx = rst_ok & mv_strobe & src_defined;
  end

endmodule

// File: rtl/regmove_checker.sv
module regmove_checker #(
  parameter int IDX_W  = 4,
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_ok,
  input logic              mv_strobe,
  input logic              src_wide,
  input logic              dst_wide,
  input logic              src_defined,
  input logic              dst_defined,
  input logic              src_mod_wide,
  input logic [DATA_W-1:0] src_data,
  input logic              pfx_load,
  input logic [BYTE_W-1:0] pfx_value,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              src_fx
);

  logic narrow_to_wide;
  assign narrow_to_wide = wr_en && src_defined && !src_wide && dst_wide;

  assert_copy8_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && src_defined && !src_wide && !dst_wide)
      |-> (wr_data == {{BYTE_W{1'b0}}, src_data[BYTE_W-1:0]}));

  assert_pfx_used_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_to_wide && $past(pfx_load) && $past(rst_ok))
      |-> (wr_data == {$past(pfx_value), src_data[BYTE_W-1:0]}));

  assert_pfx_expired_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_to_wide && !$past(pfx_load))
      |-> (wr_data[DATA_W-1:BYTE_W] == '0));

  assert_trunc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && src_defined && src_wide && !dst_wide)
      |-> (wr_data == {{BYTE_W{1'b0}}, src_data[BYTE_W-1:0]}));

  assert_copy16_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && src_defined && src_wide && dst_wide) |-> (wr_data == src_data));

  assert_nodst_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dst_defined) |-> !wr_en);

  assert_nodst_fx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && mv_strobe && src_defined && !dst_defined) |-> src_fx);

  assert_undef_wide_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !src_defined && src_mod_wide) |-> (wr_data == '0));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_ok) |-> (!wr_en && !src_fx));

  assert_fx_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!mv_strobe) |-> (!src_fx && !wr_en));

endmodule

bind regmove_unit regmove_checker #(.IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_ok       (rst_ok),
  .mv_strobe    (mv_strobe),
  .src_wide     (src_wide),
  .dst_wide     (dst_wide),
  .src_defined  (src_defined),
  .dst_defined  (dst_defined),
  .src_mod_wide (src_mod_wide),
  .src_data     (src_data),
  .pfx_load     (pfx_load),
  .pfx_value    (pfx_value),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .src_fx       (src_fx)
);

// File: tb/regmove_unit_test.sv
module regmove_unit_test;

  logic        clk;
  logic        rst_n;
  logic        mv_strobe;
  logic [3:0]  src_idx;
  logic [3:0]  dst_idx;
  logic        src_wide;
  logic        dst_wide;
  logic        src_defined;
  logic        dst_defined;
  logic        src_mod_wide;
  logic [15:0] src_data;
  logic        pfx_load;
  logic [7:0]  pfx_value;
  logic [3:0]  rd_idx;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [15:0] wr_data;
  logic        src_fx;

  int vectors = 0;
  int errors  = 0;

  logic [15:0] regs  [16];
  logic [15:0] model [16];
  logic        last_load;
  logic [7:0]  last_val;

  regmove_unit #(.IDX_W(4), .BYTE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .mv_strobe(mv_strobe),
    .src_idx(src_idx), .dst_idx(dst_idx),
    .src_wide(src_wide), .dst_wide(dst_wide),
    .src_defined(src_defined), .dst_defined(dst_defined),
    .src_mod_wide(src_mod_wide), .src_data(src_data),
    .pfx_load(pfx_load), .pfx_value(pfx_value),
    .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .src_fx(src_fx)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Register file: indices 0..7 are 8-bit, 8..15 are 16-bit
  function automatic logic is_wide(logic [3:0] i);
    return i[3];
  endfunction

  always @(posedge clk) begin
    if (wr_en) regs[wr_idx] <= wr_data;
  end

  function automatic logic [15:0] exp_word(logic [15:0] s, logic sw, logic sd,
                                           logic smw, logic dw, logic [7:0] p);
    logic [15:0] e;
    logic        ew;
    if (!sd) begin
      e  = smw ? 16'h0000 : {p, 8'h00};
      ew = 1'b1;
    end else if (sw) begin
      e  = s;
      ew = 1'b1;
    end else begin
      e  = {8'h00, s[7:0]};
      ew = 1'b0;
    end
    if (!dw) return {8'h00, e[7:0]};
    if (ew)  return e;
    return {p, e[7:0]};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic mv, logic ld, logic [7:0] pv, logic [3:0] si,
                      logic [3:0] di, logic sd, logic dd, logic smw, string req);
    logic [7:0]  cur_pfx;
    logic [15:0] ew;
    logic        en_e;
    @(negedge clk);
    mv_strobe = mv;   pfx_load = ld;     pfx_value = pv;
    src_idx = si;     dst_idx = di;
    src_wide = is_wide(si);  dst_wide = is_wide(di);
    src_defined = sd; dst_defined = dd;  src_mod_wide = smw;
    src_data = regs[si];
    #4;
    cur_pfx = last_load ? last_val : 8'h00;   // R3 model
    en_e = mv && dd;
    check({req, "/R6 wr_en"}, {15'h0, wr_en}, {15'h0, en_e});
    check({req, "/R12 src_fx"}, {15'h0, src_fx}, {15'h0, mv && sd});
    if (en_e) begin
      ew = exp_word(regs[si], is_wide(si), sd, smw, is_wide(di), cur_pfx);
      check({req, " wr_data"}, wr_data, ew);
      check({req, "/R10 wr_idx"}, {12'h0, wr_idx}, {12'h0, di});
      model[di] = ew;
    end
    last_load = ld;
    last_val  = pv;
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;  mv_strobe = 1'b0; pfx_load = 1'b0; pfx_value = 8'h00;
    src_idx = '0;  dst_idx = '0; src_wide = 1'b0; dst_wide = 1'b0;
    src_defined = 1'b1; dst_defined = 1'b1; src_mod_wide = 1'b0;
    src_data = '0; last_load = 1'b0; last_val = 8'h00;
    for (int i = 0; i < 16; i++) begin
      regs[i]  = is_wide(4'(i)) ? 16'(16'hA500 + i * 16'h0111) : 16'(8'h30 + i);
      model[i] = regs[i];
    end

    // R9: outputs held low during reset even with a move requested
    repeat (2) @(posedge clk);
    @(negedge clk);
    mv_strobe = 1'b1; pfx_load = 1'b1; pfx_value = 8'hEE;
    #4;
    check("R9 wr_en in reset", {15'h0, wr_en}, 16'h0);
    check("R9 src_fx in reset", {15'h0, src_fx}, 16'h0);
    pfx_load = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    #4;
    check("R9 wr_en one edge after release", {15'h0, wr_en}, 16'h0);
    mv_strobe = 1'b0;
    @(posedge clk);

    // R9: prefix is zero after reset (8 -> 16 move, no load)
    step(1, 0, 8'h00, 4'd2, 4'd9, 1, 1, 0, "R9 R2 pfx after reset");
    // R1: 8 -> 8
    step(1, 0, 8'h00, 4'd3, 4'd4, 1, 1, 0, "R1");
    // R2: load, then 8 -> 16
    step(0, 1, 8'h5C, 4'd0, 4'd0, 1, 1, 0, "R2 load");
    step(1, 0, 8'h00, 4'd1, 4'd10, 1, 1, 0, "R2");
    // R3: load, idle cycle, then move sees zero
    step(0, 1, 8'h77, 4'd0, 4'd0, 1, 1, 0, "R3 load");
    step(0, 0, 8'h00, 4'd0, 4'd0, 1, 1, 0, "R3 gap");
    step(1, 0, 8'h00, 4'd5, 4'd11, 1, 1, 0, "R3");
    // R11: load in same cycle as move; next move gets the new value
    step(1, 1, 8'h3D, 4'd6, 4'd12, 1, 1, 0, "R11 first");
    step(1, 1, 8'hC4, 4'd7, 4'd13, 1, 1, 0, "R11 second");
    step(1, 0, 8'h00, 4'd2, 4'd14, 1, 1, 0, "R11 third");
    // R4, R5
    step(1, 0, 8'h00, 4'd9, 4'd4, 1, 1, 0, "R4");
    step(1, 0, 8'h00, 4'd10, 4'd15, 1, 1, 0, "R5");
    // R6: undefined destination, defined source
    step(1, 0, 8'h00, 4'd8, 4'd3, 1, 0, 0, "R6");
    // R7: undefined source in mixed module, wide and narrow destination
    step(0, 1, 8'h9A, 4'd0, 4'd0, 1, 1, 0, "R7 load");
    step(1, 1, 8'h61, 4'd1, 4'd12, 0, 1, 0, "R7 wide dst");
    step(1, 0, 8'h00, 4'd1, 4'd5, 0, 1, 0, "R7 narrow dst");
    // R8: undefined source in 16-bit-only module, prefix loaded
    step(0, 1, 8'hB2, 4'd0, 4'd0, 1, 1, 0, "R8 load");
    step(1, 0, 8'h00, 4'd8, 4'd13, 0, 1, 1, "R8");

    // Random traffic
    for (int n = 0; n < 600; n++) begin
      logic [3:0] rs = 4'($urandom);
      logic [3:0] rd = 4'($urandom);
      step(($urandom % 4) != 0, ($urandom % 3) == 0, 8'($urandom), rs, rd,
           ($urandom % 8) != 0, ($urandom % 8) != 0, 1'($urandom), "random");
    end

    @(negedge clk);
    mv_strobe = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      check("R10 register file contents", regs[i], model[i]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule